// File: doc/BRIEF.md
# Interrupt Status and Cause Unit

This unit sits beside a processor pipeline and owns two control registers: a status register and a cause register. The status register carries a three-level stack of interrupt-enable and privilege-mode bits in its low six bits, plus one mask bit per interrupt line. The cause register shows the live level of every interrupt line and the code of the last exception or interrupt that was taken. From these two registers the unit decides, every cycle, whether an external interrupt is taken. When one is taken, it signals the pipeline with `irq_take`.

Interrupt line 0 comes from a memory-mapped terminal receiver. That line is high while the receiver holds a character and its local interrupt enable is set. The other lines come straight from other devices.

Taking an interrupt or recording a synchronous exception pushes the mode/enable stack. This drops the core into kernel mode with interrupts off in a single step. A return-from-exception command pops the stack. Software reads the two registers and writes the status register through a small move-to/move-from coprocessor port. Register 12 selects status and register 13 selects cause.

Top module: `irq_status_cause`

## Requirements
- R1: After reset the status register and the exception code are zero, and `irq_take` is low.
- R2: `irq_take` is high in the same cycle exactly when status bit 0 is 1 and, for at least one line i, the line is high and status bit 8+i is 1. After a take, `irq_take` is low in the following cycle.
- R3: Interrupt line 0 equals `term_rdy` AND `term_ie`. It is shown at cause bit 8 and is qualified by status mask bit 8.
- R4: Cause bits 15:8 show the raw level of lines 7..0, whatever the mask and enable bits are.
- R5: At the clock edge where `irq_take` is high, status bits 5:0 become their old bits 3:0 followed by two zeros, and the cause code field (bits 6:2) becomes 0.
- R6: On `rfe` with no take or exception in that cycle, status bits 5:4 keep their value, bits 3:0 receive the old bits 5:2, and bits 15:8 are unchanged.
- R7: A move-to with `cop_addr`=12 loads status bits 15:8 and 5:0 from the write data. All other status bits read 0. Reads of addresses 12 and 13 are combinational, and any other address reads 0.
- R8: A take has priority. In its cycle a status write, an `rfe` or an exception is ignored. Any of take, exception or `rfe` also blocks a status write.
- R9: `exc_valid` with no take pushes the stack exactly as in R5 and records `exc_code` in cause bits 6:2.
- R10: A move-to with `cop_addr`=13 has no effect on the cause register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| term_rdy | input | 1 | Terminal receiver holds a character |
| term_ie | input | 1 | Terminal receiver local interrupt enable |
| ext_irq | input | 7 | Interrupt lines 7..1 |
| cop_addr | input | 5 | Coprocessor register select (12 status, 13 cause) |
| cop_we | input | 1 | Move-to strobe |
| cop_wdata | input | 32 | Move-to data |
| cop_rdata | output | 32 | Move-from data, combinational |
| rfe | input | 1 | Return-from-exception command |
| exc_valid | input | 1 | Synchronous exception to record |
| exc_code | input | 5 | Code of that exception |
| irq_take | output | 1 | External interrupt taken this cycle |

## Verification
The assertions assume that the pipeline drops its interrupt lines or keeps interrupts disabled in the cycle after a take. They also assume that `rfe` and `exc_valid` are single-cycle pulses that are never combined with a take the property does not expect. The stimulus follows these assumptions. It drives every command for exactly one cycle, and it lowers device lines before issuing `rfe` whenever re-enabling would otherwise cause an immediate second take. Priority collisions are created on purpose, and only in the tests that exercise R8.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_IRQ   = 8;
    localparam int CODE_W    = 5;
    localparam int ADDR_W    = 5;
    localparam int STACK_W   = 6;
    localparam int MASK_LSB  = 8;
    localparam int CODE_LSB  = 2;
    localparam logic [ADDR_W-1:0] SEL_STATUS = 5'd12;
    localparam logic [ADDR_W-1:0] SEL_CAUSE  = 5'd13;
    localparam logic [CODE_W-1:0] CODE_EXT_IRQ = '0;

    // bit 5 .. bit 0 : old KU, old IE, prev KU, prev IE, cur KU, cur IE
    typedef struct packed {
        logic ku_old;
        logic ie_old;
        logic ku_prev;
        logic ie_prev;
        logic ku_cur;
        logic ie_cur;
    } mode_stack_t;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_LOAD = 2'd3
    } stack_op_e;

    function automatic mode_stack_t stack_push(input mode_stack_t s);
        mode_stack_t r;
        r.ku_old  = s.ku_prev;
        r.ie_old  = s.ie_prev;
        r.ku_prev = s.ku_cur;
        r.ie_prev = s.ie_cur;
        r.ku_cur  = 1'b0;
        r.ie_cur  = 1'b0;
        return r;
    endfunction

    function automatic mode_stack_t stack_pop(input mode_stack_t s);
        mode_stack_t r;
        r.ku_old  = s.ku_old;
        r.ie_old  = s.ie_old;
        r.ku_prev = s.ku_old;
        r.ie_prev = s.ie_old;
        r.ku_cur  = s.ku_prev;
        r.ie_cur  = s.ie_prev;
        return r;
    endfunction

endpackage

// File: rtl/irq_line_gather.sv
module irq_line_gather
    import irq_ctl_pkg::*;
#(
    parameter int LINES = NUM_IRQ
) (
    input  logic             term_rdy,
    input  logic             term_ie,
    input  logic [LINES-2:0] ext_irq,
    output logic [LINES-1:0] lines
);
    assign lines[0] = term_rdy & term_ie;

    for (genvar i = 1; i < LINES; i++) begin : g_ext
        assign lines[i] = ext_irq[i-1];
    end
endmodule

// File: rtl/irq_qualify.sv
module irq_qualify
    import irq_ctl_pkg::*;
#(
    parameter int LINES = NUM_IRQ
) (
    input  logic             global_ie,
    input  logic [LINES-1:0] lines,
    input  logic [LINES-1:0] mask,
    output logic             take
);
    logic [LINES-1:0] armed;

    for (genvar i = 0; i < LINES; i++) begin : g_arm
        assign armed[i] = lines[i] & mask[i];
    end

    assign take = global_ie & (|armed);
endmodule

// File: rtl/mode_stack_reg.sv
module mode_stack_reg
    import irq_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  stack_op_e   op,
    input  mode_stack_t load_val,
    output mode_stack_t stack_q
);
    mode_stack_t stack_d;

    always_comb begin
        unique case (op)
            OP_PUSH: stack_d = stack_push(stack_q);
            OP_POP:  stack_d = stack_pop(stack_q);
            OP_LOAD: stack_d = load_val;
            default: stack_d = stack_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) stack_q <= '0;
        else     stack_q <= stack_d;
    end
endmodule

// File: rtl/cause_reg.sv
module cause_reg
    import irq_ctl_pkg::*;
#(
    parameter int LINES = NUM_IRQ
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rec_en,
    input  logic [CODE_W-1:0] rec_code,
    input  logic [LINES-1:0]  lines,
    output logic [DATA_W-1:0] cause_word
);
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst)         code_q <= '0;
        else if (rec_en) code_q <= rec_code;
    end

    always_comb begin
        cause_word = '0;
        cause_word[CODE_LSB +: CODE_W] = code_q;
        cause_word[MASK_LSB +: LINES]  = lines;
    end
endmodule

// File: rtl/irq_status_cause.sv
module irq_status_cause
    import irq_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               term_rdy,
    input  logic               term_ie,
    input  logic [NUM_IRQ-2:0] ext_irq,
    input  logic [ADDR_W-1:0]  cop_addr,
    input  logic               cop_we,
    input  logic [DATA_W-1:0]  cop_wdata,
    output logic [DATA_W-1:0]  cop_rdata,
    input  logic               rfe,
    input  logic               exc_valid,
    input  logic [CODE_W-1:0]  exc_code,
    output logic               irq_take
);
    logic [NUM_IRQ-1:0] irq_lines;
    logic [NUM_IRQ-1:0] mask_q;
    mode_stack_t        stack_q;
    stack_op_e          op;
    logic               status_wr;
    logic               rec_en;
    logic [CODE_W-1:0]  rec_code;
    logic [DATA_W-1:0]  status_word;
    logic [DATA_W-1:0]  cause_word;

    irq_line_gather #(.LINES(NUM_IRQ)) u_gather (
        .term_rdy (term_rdy),
        .term_ie  (term_ie),
        .ext_irq  (ext_irq),
        .lines    (irq_lines)
    );

    irq_qualify #(.LINES(NUM_IRQ)) u_qual (
        .global_ie (stack_q.ie_cur),
        .lines     (irq_lines),
        .mask      (mask_q),
        .take      (irq_take)
    );

    // priority: interrupt entry, exception entry, return, software write
    always_comb begin
        status_wr = cop_we && (cop_addr == SEL_STATUS);
        if (irq_take || exc_valid) op = OP_PUSH;
        else if (rfe)              op = OP_POP;
        else if (status_wr)        op = OP_LOAD;
        else                       op = OP_HOLD;
        rec_en   = irq_take || exc_valid;
        rec_code = irq_take ? CODE_EXT_IRQ : exc_code;
    end

    mode_stack_reg u_stack (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .load_val (mode_stack_t'(cop_wdata[STACK_W-1:0])),
        .stack_q  (stack_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                mask_q <= '0;
        else if (op == OP_LOAD) mask_q <= cop_wdata[MASK_LSB +: NUM_IRQ];
    end

    cause_reg #(.LINES(NUM_IRQ)) u_cause (
        .clk        (clk),
        .rst        (rst),
        .rec_en     (rec_en),
        .rec_code   (rec_code),
        .lines      (irq_lines),
        .cause_word (cause_word)
    );

    always_comb begin
        status_word = '0;
        status_word[STACK_W-1:0]       = stack_q;
        status_word[MASK_LSB +: NUM_IRQ] = mask_q;
        unique case (cop_addr)
            SEL_STATUS: cop_rdata = status_word;
            SEL_CAUSE:  cop_rdata = cause_word;
            default:    cop_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_status_cause_chk.sv
module irq_status_cause_chk
    import irq_ctl_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               irq_take,
    input logic               rfe,
    input logic               exc_valid,
    input logic [NUM_IRQ-1:0] lines,
    input logic [DATA_W-1:0]  status_w,
    input logic [DATA_W-1:0]  cause_w
);
    a_r2_take_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> status_w[0]);

    a_r2_take_needs_masked_line: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> (|(lines & status_w[MASK_LSB +: NUM_IRQ])));

    a_r2_single_take: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> !irq_take);

    a_r5_push_on_take: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> status_w[5:0] == {$past(status_w[3:0]), 2'b00});

    a_r5_code_zero: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> cause_w[6:2] == 5'd0);

    a_r6_pop: assert property (@(posedge clk) disable iff (rst)
        (rfe && !irq_take && !exc_valid) |=>
            status_w[5:0] == {$past(status_w[5:4]), $past(status_w[5:2])});

    a_r4_pending_mirror: assert property (@(posedge clk) disable iff (rst)
        cause_w[MASK_LSB +: NUM_IRQ] == lines);

    a_r8_mask_kept_on_take: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> status_w[MASK_LSB +: NUM_IRQ] == $past(status_w[MASK_LSB +: NUM_IRQ]));
endmodule

bind irq_status_cause irq_status_cause_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_take  (irq_take),
    .rfe       (rfe),
    .exc_valid (exc_valid),
    .lines     (irq_lines),
    .status_w  (status_word),
    .cause_w   (cause_word)
);

// File: tb/test_irq_status_cause.sv
`timescale 1ns/1ps
module test_irq_status_cause;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        term_rdy = 1'b0;
    logic        term_ie = 1'b0;
    logic [6:0]  ext_irq = '0;
    logic [4:0]  cop_addr = '0;
    logic        cop_we = 1'b0;
    logic [31:0] cop_wdata = '0;
    logic [31:0] cop_rdata;
    logic        rfe = 1'b0;
    logic        exc_valid = 1'b0;
    logic [4:0]  exc_code = '0;
    logic        irq_take;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_cause i_irq_status_cause (
        .clk(clk), .rst(rst), .term_rdy(term_rdy), .term_ie(term_ie),
        .ext_irq(ext_irq), .cop_addr(cop_addr), .cop_we(cop_we),
        .cop_wdata(cop_wdata), .cop_rdata(cop_rdata), .rfe(rfe),
        .exc_valid(exc_valid), .exc_code(exc_code), .irq_take(irq_take)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        cop_addr = a;
        #1;
        v = cop_rdata;
    endtask

    task automatic wr_status(input logic [31:0] d);
        cop_addr = 5'd12; cop_wdata = d; cop_we = 1'b1;
        step();
        cop_we = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(5'd12, v); check("R1 status", v, 32'h0);
        rd(5'd13, v); check("R1 cause", v, 32'h0);
        check("R1 take", {31'd0, irq_take}, 32'h0);
    endtask

    task automatic t_access();
        logic [31:0] v;
        wr_status(32'hFFFF_FFFF);
        rd(5'd12, v); check("R7 writable bits", v, 32'h0000_FF3F);
        wr_status(32'h0000_A512);
        rd(5'd12, v); check("R7 pattern", v, 32'h0000_A512);
        rd(5'd3, v);  check("R7 other addr", v, 32'h0);
        cop_addr = 5'd13; cop_wdata = 32'hFFFF_FFFF; cop_we = 1'b1;
        step(); cop_we = 1'b0;
        rd(5'd13, v); check("R10 cause write ignored", v, 32'h0);
        wr_status(32'h0);
    endtask

    task automatic t_pending();
        logic [31:0] v;
        ext_irq = 7'b1010101; term_rdy = 1'b1; term_ie = 1'b0;
        rd(5'd13, v); check("R4 raw lines", v, 32'h0000_AA00);
        check("R4 no take masked", {31'd0, irq_take}, 32'h0);
        term_ie = 1'b1;
        rd(5'd13, v); check("R3 line0 shown", v, 32'h0000_AB00);
        ext_irq = '0; term_rdy = 1'b0; term_ie = 1'b0;
        rd(5'd13, v); check("R4 lines low", v, 32'h0);
    endtask

    task automatic t_term_take();
        logic [31:0] v;
        wr_status(32'h0000_010B);
        term_ie = 1'b1; #1;
        check("R3 ie without ready", {31'd0, irq_take}, 32'h0);
        term_rdy = 1'b1; #1;
        check("R2 take asserted", {31'd0, irq_take}, 32'h1);
        step();
        rd(5'd12, v); check("R5 push", v, 32'h0000_012C);
        rd(5'd13, v); check("R5 code zero", v, 32'h0000_0100);
        check("R2 take drops", {31'd0, irq_take}, 32'h0);
        term_rdy = 1'b0; term_ie = 1'b0;
    endtask

    task automatic t_rfe();
        logic [31:0] v;
        rfe = 1'b1; step(); rfe = 1'b0;
        rd(5'd12, v); check("R6 pop", v, 32'h0000_012B);
    endtask

    task automatic t_qualify();
        logic [31:0] v;
        wr_status(32'h0000_0001);
        ext_irq = 7'b0000100; #1;
        check("R2 mask off", {31'd0, irq_take}, 32'h0);
        wr_status(32'h0000_0800);
        check("R2 enable off", {31'd0, irq_take}, 32'h0);
        wr_status(32'h0000_0801);
        check("R2 line3 take", {31'd0, irq_take}, 32'h1);
        step();
        rd(5'd12, v); check("R5 push line3", v, 32'h0000_0804);
        ext_irq = '0;
    endtask

    task automatic t_exc();
        logic [31:0] v;
        wr_status(32'h0000_0005);
        exc_valid = 1'b1; exc_code = 5'd12;
        step(); exc_valid = 1'b0;
        rd(5'd12, v); check("R9 exc push", v, 32'h0000_0014);
        rd(5'd13, v); check("R9 exc code", v, 32'h0000_0030);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        wr_status(32'h0000_0107);
        term_ie = 1'b1; term_rdy = 1'b1;
        exc_valid = 1'b1; exc_code = 5'd9; rfe = 1'b1;
        cop_addr = 5'd12; cop_wdata = 32'h0; cop_we = 1'b1; #1;
        check("R8 take with collisions", {31'd0, irq_take}, 32'h1);
        step();
        cop_we = 1'b0; exc_valid = 1'b0; rfe = 1'b0;
        term_ie = 1'b0; term_rdy = 1'b0;
        rd(5'd12, v); check("R8 write ignored", v, 32'h0000_011C);
        rd(5'd13, v); check("R8 code from take", v, 32'h0);
        wr_status(32'h0000_0004);
        rfe = 1'b1; cop_addr = 5'd12; cop_wdata = 32'h0000_FF00; cop_we = 1'b1;
        step(); rfe = 1'b0; cop_we = 1'b0;
        rd(5'd12, v); check("R8 rfe blocks write", v, 32'h0000_0001);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        step(); step();
        rst = 1'b0;
        t_reset();
        t_access();
        t_pending();
        t_term_take();
        t_rfe();
        t_qualify();
        t_exc();
        t_priority();
        step();
        finish_run();
    end
endmodule